// File: doc/BRIEF.md
# Reorder Buffer with Deferred Faults

This block is a circular retirement buffer for an out-of-order core. A dispatch stage allocates one entry per instruction at the tail and receives the entry's index as its tag. Execution units later report completion against that tag, either with a result value or with a fault code. Entries leave from the head in program order and appear on a set of commit ports. Up to `COMMIT_W` entries leave per cycle, and the oldest entry is always on slot 0.

A fault is never reported when it is detected. It is kept in the entry as if it were a result. The exception output rises only when the faulting entry is the oldest live entry. In that same cycle the faulting entry and everything younger than it are discarded, and the exception pulse doubles as the redirect request towards the handler. A mispredicted branch, identified by its tag, discards every entry younger than the branch. Faults held in those wrong-path entries therefore disappear without ever being raised.

Top module: `rob_deferred_fault`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `commit_valid` is all zero and `exc_valid` is 0.
- R2: A dispatch is accepted on a rising edge where `disp_valid` and `disp_ready` are both 1 and no mispredict flush is accepted. It takes the entry at `disp_tag`, and `disp_tag` then advances by one modulo `DEPTH`.
- R3: With `DEPTH` live entries, or while `exc_valid` is 1, `disp_ready` is 0 and `disp_valid` has no effect.
- R4: A writeback to a live tag marks that entry complete, storing the data, the fault flag (1 means faulted) and the code. A writeback to a tag that is not live is ignored, so an entry allocated later at that index is still incomplete.
- R5: Each cycle the commit ports show the longest run of completed, non-faulting entries starting at the head, capped at `COMMIT_W`. Slot `s` shows the entry `s` places from the head, with its destination and data, and that entry leaves on the clock edge.
- R6: A fault is not visible until its entry is at the head. Then `exc_valid` is 1 and `exc_code` carries the stored code, no commit slot is valid, and the faulting entry's result is never presented on a commit port.
- R7: On an edge where `exc_valid` is 1, all entries are discarded. The next allocation uses the tail index that was current before the exception.
- R8: A flush with a live `flush_tag` discards every entry younger than the branch, so the next tag is `flush_tag`+1. Older entries may still commit in the same cycle, a dispatch offered in that cycle is dropped, and a flush naming a tag that is not live is ignored.
- R9: A flush offered while `exc_valid` is 1 has no effect; the exception's full discard wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | REG_W | Destination register of the dispatched instruction |
| disp_ready | output | 1 | Buffer can accept a dispatch |
| disp_tag | output | IDX_W | Index the next dispatch will take |
| wb_valid | input | 1 | Completion report |
| wb_tag | input | IDX_W | Entry being completed |
| wb_data | input | DATA_W | Result value |
| wb_fault | input | 1 | 1 when execution faulted |
| wb_code | input | CODE_W | Fault code |
| flush_valid | input | 1 | Mispredicted branch report |
| flush_tag | input | IDX_W | Tag of the mispredicted branch |
| commit_valid | output | COMMIT_W | Per-slot retire strobe, bit 0 oldest |
| commit_dest | output | COMMIT_W*REG_W | Per-slot destination, slot s at bits s*REG_W |
| commit_data | output | COMMIT_W*DATA_W | Per-slot result, slot s at bits s*DATA_W |
| exc_valid | output | 1 | Head faulted: raise exception, discard all, redirect to the handler |
| exc_code | output | CODE_W | Fault code of the head entry |

## Verification
The assertions assume that execution units report each live tag at most once and never report a tag after its entry has been discarded and reallocated. They also assume that a branch reported as mispredicted is live. The bench keeps to these assumptions: it chooses writeback tags only among live, incomplete entries of its own queue model, and it chooses flush tags only among that model's live entries. The two exceptions are deliberate. One directed writeback targets a free index, and one directed flush arrives during an exception cycle, so that the "ignored" requirements are exercised at the ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Completion state kept per entry
   typedef struct packed {
      logic done;
      logic fault;
   } rob_flag_t;

   localparam rob_flag_t ROB_FLAG_IDLE = '{done: 1'b0, fault: 1'b0};

endpackage

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
   parameter int DEPTH    = 16,
   parameter int COMMIT_W = 2,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc,
   input  logic [CNT_W-1:0] ncommit,
   input  logic             disp_fire,
   input  logic             flush_valid,
   input  logic [IDX_W-1:0] flush_tag,
   input  logic             wb_valid,
   input  logic [IDX_W-1:0] wb_tag,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] live_cnt,
   output logic             flush_ok,
   output logic             wb_live
);

   logic [IDX_W-1:0] fdist;
   logic [IDX_W-1:0] wdist;

   always_comb begin
      tail     = head + count[IDX_W-1:0];
      fdist    = flush_tag - head;
      wdist    = wb_tag - head;
      flush_ok = flush_valid && (CNT_W'(fdist) < count);
      live_cnt = flush_ok ? CNT_W'(fdist) + CNT_W'(1) : count;
      wb_live  = wb_valid && (CNT_W'(wdist) < count);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else if (exc) begin
         head  <= tail;
         count <= '0;
      end else begin
         head  <= head + IDX_W'(ncommit);
         count <= live_cnt - ncommit + CNT_W'(disp_fire);
      end
   end

   // R3: occupancy never exceeds the ring size
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R7: an exception leaves the ring empty
   a_r7_exc_empties: assert property (@(posedge clk) disable iff (!rst_n)
      exc |=> (count == '0));

   // R8: an accepted flush never grows the ring
   a_r8_flush_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_ok && !exc) |=> (count <= $past(count)));

   // R5: without flush the ring drains by at most COMMIT_W per cycle
   a_r5_drain_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_ok && !exc) |=> (int'(count) + COMMIT_W >= int'($past(count))));

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
   import rob_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int COMMIT_W = 2,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 32,
   parameter int CODE_W   = 4,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_en,
   input  logic [IDX_W-1:0]           alloc_idx,
   input  logic [REG_W-1:0]           alloc_dest,
   input  logic                       wb_en,
   input  logic [IDX_W-1:0]           wb_idx,
   input  logic [DATA_W-1:0]          wb_data,
   input  logic                       wb_fault,
   input  logic [CODE_W-1:0]          wb_code,
   input  logic [IDX_W-1:0]           head,
   output logic [COMMIT_W-1:0]        slot_done,
   output logic [COMMIT_W-1:0]        slot_fault,
   output logic [COMMIT_W*REG_W-1:0]  slot_dest,
   output logic [COMMIT_W*DATA_W-1:0] slot_data,
   output logic [CODE_W-1:0]          head_code
);

   rob_flag_t         flags [DEPTH];
   logic [REG_W-1:0]  dests [DEPTH];
   logic [DATA_W-1:0] datas [DEPTH];
   logic [CODE_W-1:0] codes [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      localparam logic [IDX_W-1:0] EIDX = IDX_W'(e);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[e] <= ROB_FLAG_IDLE;
         end else if (alloc_en && alloc_idx == EIDX) begin
            flags[e] <= ROB_FLAG_IDLE;
         end else if (wb_en && wb_idx == EIDX) begin
            flags[e] <= '{done: 1'b1, fault: wb_fault};
         end
      end

      always_ff @(posedge clk) begin
         if (alloc_en && alloc_idx == EIDX) begin
            dests[e] <= alloc_dest;
         end
         if (wb_en && wb_idx == EIDX) begin
            datas[e] <= wb_data;
            codes[e] <= wb_code;
         end
      end
   end

   for (genvar s = 0; s < COMMIT_W; s++) begin : g_slot
      logic [IDX_W-1:0] ridx;
      always_comb begin
         ridx                           = head + IDX_W'(s);
         slot_done[s]                   = flags[ridx].done;
         slot_fault[s]                  = flags[ridx].fault;
         slot_dest[s*REG_W +: REG_W]    = dests[ridx];
         slot_data[s*DATA_W +: DATA_W]  = datas[ridx];
      end
   end

   assign head_code = codes[head];

   // R4: an accepted writeback leaves its entry complete
   a_r4_wb_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !(alloc_en && alloc_idx == wb_idx)) |=> flags[$past(wb_idx)].done);

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
   parameter int COMMIT_W = 2,
   parameter int DEPTH    = 16,
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [COMMIT_W-1:0] slot_done,
   input  logic [COMMIT_W-1:0] slot_fault,
   input  logic [CNT_W-1:0]    live_cnt,
   output logic [COMMIT_W-1:0] commit_ok,
   output logic [CNT_W-1:0]    ncommit,
   output logic                exc
);

   logic head_live;
   assign head_live = (live_cnt != '0);
   assign exc       = head_live && slot_done[0] && slot_fault[0];

   if (COMMIT_W == 1) begin : g_single
      assign commit_ok[0] = head_live && slot_done[0] && !slot_fault[0];
   end else begin : g_multi
      for (genvar s = 0; s < COMMIT_W; s++) begin : g_lane
         logic lane_ready;
         assign lane_ready = (CNT_W'(s) < live_cnt) && slot_done[s] && !slot_fault[s];
         if (s == 0) begin : g_first
            assign commit_ok[s] = lane_ready;
         end else begin : g_rest
            assign commit_ok[s] = lane_ready && commit_ok[s-1];
         end
      end
   end

   always_comb begin
      ncommit = '0;
      for (int s = 0; s < COMMIT_W; s++) begin
         ncommit = ncommit + CNT_W'(commit_ok[s]);
      end
   end

   // R6: a faulting head blocks every commit slot
   a_r6_exc_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> (commit_ok == '0));

   // R5: never retire more entries than are live
   a_r5_within_live: assert property (@(posedge clk) disable iff (!rst_n)
      ncommit <= live_cnt);

endmodule

// File: rtl/rob_deferred_fault.sv
module rob_deferred_fault #(
   parameter int DEPTH    = 16,
   parameter int COMMIT_W = 2,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 32,
   parameter int CODE_W   = 4,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       disp_valid,
   input  logic [REG_W-1:0]           disp_dest,
   output logic                       disp_ready,
   output logic [IDX_W-1:0]           disp_tag,
   input  logic                       wb_valid,
   input  logic [IDX_W-1:0]           wb_tag,
   input  logic [DATA_W-1:0]          wb_data,
   input  logic                       wb_fault,
   input  logic [CODE_W-1:0]          wb_code,
   input  logic                       flush_valid,
   input  logic [IDX_W-1:0]           flush_tag,
   output logic [COMMIT_W-1:0]        commit_valid,
   output logic [COMMIT_W*REG_W-1:0]  commit_dest,
   output logic [COMMIT_W*DATA_W-1:0] commit_data,
   output logic                       exc_valid,
   output logic [CODE_W-1:0]          exc_code
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (COMMIT_W < 1 || COMMIT_W > DEPTH) begin : g_bad_width
      $error("COMMIT_W must lie between 1 and DEPTH");
   end

   logic [IDX_W-1:0]    head;
   logic [IDX_W-1:0]    tail;
   logic [CNT_W-1:0]    count;
   logic [CNT_W-1:0]    live_cnt;
   logic [CNT_W-1:0]    ncommit;
   logic                flush_ok;
   logic                wb_live;
   logic                exc;
   logic                disp_fire;
   logic [COMMIT_W-1:0] slot_done;
   logic [COMMIT_W-1:0] slot_fault;

   assign disp_ready = (count != CNT_W'(DEPTH)) && !exc;
   assign disp_fire  = disp_valid && disp_ready && !flush_ok;
   assign disp_tag   = tail;
   assign exc_valid  = exc;

   rob_ring_ctrl #(.DEPTH(DEPTH), .COMMIT_W(COMMIT_W)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .exc         (exc),
      .ncommit     (ncommit),
      .disp_fire   (disp_fire),
      .flush_valid (flush_valid),
      .flush_tag   (flush_tag),
      .wb_valid    (wb_valid),
      .wb_tag      (wb_tag),
      .head        (head),
      .tail        (tail),
      .count       (count),
      .live_cnt    (live_cnt),
      .flush_ok    (flush_ok),
      .wb_live     (wb_live)
   );

   rob_entry_store #(
      .DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .REG_W(REG_W),
      .DATA_W(DATA_W), .CODE_W(CODE_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (disp_fire),
      .alloc_idx  (tail),
      .alloc_dest (disp_dest),
      .wb_en      (wb_live),
      .wb_idx     (wb_tag),
      .wb_data    (wb_data),
      .wb_fault   (wb_fault),
      .wb_code    (wb_code),
      .head       (head),
      .slot_done  (slot_done),
      .slot_fault (slot_fault),
      .slot_dest  (commit_dest),
      .slot_data  (commit_data),
      .head_code  (exc_code)
   );

   rob_retire_sel #(.COMMIT_W(COMMIT_W), .DEPTH(DEPTH)) u_retire (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_done  (slot_done),
      .slot_fault (slot_fault),
      .live_cnt   (live_cnt),
      .commit_ok  (commit_valid),
      .ncommit    (ncommit),
      .exc        (exc)
   );

   // R2: an accepted dispatch moves the tail by exactly one
   a_r2_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_fire && !exc) |=> (disp_tag == $past(disp_tag) + IDX_W'(1)));

   // R9: a flush during an exception leaves the tail where it was
   a_r9_exc_over_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (exc && flush_valid) |=> (disp_tag == $past(disp_tag)));

endmodule

// File: tb/tb_rob_deferred_fault.sv
`timescale 1ns/1ps
module tb_rob_deferred_fault;

   localparam int D  = 16;
   localparam int W  = 2;
   localparam int RW = 5;
   localparam int DW = 32;
   localparam int CW = 4;
   localparam int IW = $clog2(D);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            disp_valid = 1'b0;
   logic [RW-1:0]   disp_dest = '0;
   logic            disp_ready;
   logic [IW-1:0]   disp_tag;
   logic            wb_valid = 1'b0;
   logic [IW-1:0]   wb_tag = '0;
   logic [DW-1:0]   wb_data = '0;
   logic            wb_fault = 1'b0;
   logic [CW-1:0]   wb_code = '0;
   logic            flush_valid = 1'b0;
   logic [IW-1:0]   flush_tag = '0;
   logic [W-1:0]    commit_valid;
   logic [W*RW-1:0] commit_dest;
   logic [W*DW-1:0] commit_data;
   logic            exc_valid;
   logic [CW-1:0]   exc_code;

   always #4 clk = ~clk;

   rob_deferred_fault #(.DEPTH(D), .COMMIT_W(W), .REG_W(RW), .DATA_W(DW), .CODE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_ready(disp_ready), .disp_tag(disp_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_fault(wb_fault), .wb_code(wb_code),
      .flush_valid(flush_valid), .flush_tag(flush_tag),
      .commit_valid(commit_valid), .commit_dest(commit_dest), .commit_data(commit_data),
      .exc_valid(exc_valid), .exc_code(exc_code)
   );

   typedef struct {
      int tag;
      int dest;
      int data;
      bit done;
      bit fault;
      int code;
   } ment_t;

   ment_t mq[$];
   int    mtail = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    ended = 1'b0;
   string tag_req = "R2";
   string commit_req = "R5";

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One clock of stimulus, comparison against the queue model, then model update
   task automatic step(bit dv, int dest, bit wv, int wtag, int wdata, bit wf, int wcode,
                       bit fv, int ftag);
      int fj;
      int live;
      int n;
      bit ex;
      bit rdy;
      @(negedge clk);
      disp_valid  = dv;
      disp_dest   = RW'(dest);
      wb_valid    = wv;
      wb_tag      = IW'(wtag);
      wb_data     = DW'(wdata);
      wb_fault    = wf;
      wb_code     = CW'(wcode);
      flush_valid = fv;
      flush_tag   = IW'(ftag);
      ex = (mq.size() > 0) && mq[0].done && mq[0].fault;
      fj = -1;
      if (fv && !ex) begin
         for (int i = 0; i < mq.size(); i++) if (mq[i].tag == ftag) fj = i;
      end
      live = (fj >= 0) ? fj + 1 : mq.size();
      n = 0;
      if (!ex) begin
         while (n < W && n < live && mq[n].done && !mq[n].fault) n++;
      end
      rdy = (mq.size() < D) && !ex;
      #1;
      chk(disp_ready === rdy, "R3", "disp_ready", disp_ready, rdy);
      chk(disp_tag == IW'(mtail), tag_req, "disp_tag", disp_tag, mtail);
      chk(exc_valid === ex, "R6", "exc_valid", exc_valid, ex);
      if (ex) chk(exc_code == CW'(mq[0].code), "R6", "exc_code", exc_code, mq[0].code);
      for (int s = 0; s < W; s++) begin
         bit ev;
         ev = (s < n);
         chk(commit_valid[s] === ev, commit_req, "commit_valid slot", commit_valid[s], ev);
         if (ev) begin
            chk(commit_dest[s*RW +: RW] == RW'(mq[s].dest), commit_req, "commit_dest",
                commit_dest[s*RW +: RW], mq[s].dest);
            chk(commit_data[s*DW +: DW] == DW'(mq[s].data), commit_req, "commit_data",
                commit_data[s*DW +: DW], mq[s].data);
         end
      end
      @(posedge clk);
      tag_req = "R2";
      if (ex) begin
         mq.delete();
         tag_req = fv ? "R9" : "R7";
      end else begin
         if (wv) begin
            for (int i = 0; i < mq.size(); i++) begin
               if (mq[i].tag == wtag && !mq[i].done) begin
                  mq[i].done  = 1'b1;
                  mq[i].fault = wf;
                  mq[i].data  = wdata;
                  mq[i].code  = wcode % (1 << CW);
               end
            end
         end
         if (fj >= 0) begin
            while (mq.size() > fj + 1) void'(mq.pop_back());
         end
         repeat (n) void'(mq.pop_front());
         if (fj >= 0) begin
            mtail = (ftag + 1) % D;
            tag_req = "R8";
         end else if (dv && rdy) begin
            mq.push_back('{tag: mtail, dest: dest % (1 << RW), data: 0, done: 1'b0, fault: 1'b0, code: 0});
            mtail = (mtail + 1) % D;
         end
      end
   endtask

   task automatic idle(int cycles);
      repeat (cycles) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic disp(int dest);
      step(1, dest, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wb(int tag, int data, bit f, int code);
      step(0, 0, 1, tag, data, f, code, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(disp_ready === 1'b1, "R1", "disp_ready after reset", disp_ready, 1);
      chk(disp_tag == '0, "R1", "disp_tag after reset", disp_tag, 0);
      chk(commit_valid == '0, "R1", "commit_valid after reset", commit_valid, 0);
      chk(exc_valid === 1'b0, "R1", "exc_valid after reset", exc_valid, 0);

      // R3: fill past capacity, the extra dispatches are refused
      for (int i = 0; i < D + 2; i++) disp(i);
      // completion in reverse order, then retirement two per cycle (R5)
      for (int i = D - 1; i >= 0; i--) wb(i, 1000 + i, 0, 0);
      idle(10);

      // R6: older entries retire before the fault at the head is raised
      base = mtail;
      for (int i = 0; i < 4; i++) disp(20 + i);
      wb((base + 3) % D, 7, 0, 0);
      wb((base + 2) % D, 66, 1, 9);
      wb(base, 5, 0, 0);
      wb((base + 1) % D, 6, 0, 0);
      idle(4);

      // R8: a fault behind a mispredicted branch is squashed
      base = mtail;
      for (int i = 0; i < 4; i++) disp(8 + i);
      wb((base + 3) % D, 99, 1, 3);
      step(1, 2, 0, 0, 0, 0, 0, 1, (base + 1) % D);
      wb(base, 11, 0, 0);
      wb((base + 1) % D, 12, 0, 0);
      idle(4);

      // R4: a writeback to a free index does nothing
      commit_req = "R4";
      base = mtail;
      wb(base, 55, 0, 0);
      disp(17);
      idle(3);
      wb(base, 56, 0, 0);
      idle(2);
      commit_req = "R5";

      // R9: a flush during the exception cycle is overridden
      base = mtail;
      for (int i = 0; i < 3; i++) disp(i + 1);
      wb(base, 1, 1, 12);
      step(0, 0, 0, 0, 0, 0, 0, 1, (base + 1) % D);
      idle(2);

      // mixed traffic with random faults and flushes
      for (int c = 0; c < 4000; c++) begin
         bit dv, wv, wf, fv;
         int dest, wtag, wdata, wcode, ftag;
         int cand[$];
         dv = ($urandom % 4) != 0;
         dest = int'($urandom % 32);
         wv = 1'b0; wtag = 0; wf = 1'b0;
         wdata = int'($urandom);
         wcode = int'($urandom % 16);
         cand.delete();
         for (int i = 0; i < mq.size(); i++) if (!mq[i].done) cand.push_back(mq[i].tag);
         if (cand.size() > 0 && ($urandom % 3) != 0) begin
            wv = 1'b1;
            wtag = cand[$urandom % cand.size()];
            wf = ($urandom % 12) == 0;
         end
         fv = 1'b0; ftag = 0;
         if (mq.size() > 0 && ($urandom % 20) == 0) begin
            fv = 1'b1;
            ftag = mq[$urandom % mq.size()].tag;
         end
         step(dv, dest, wv, wtag, wdata, wf, wcode, fv, ftag);
      end
      idle(4);
      finish_up();
   end

endmodule